// File: doc/BRIEF.md
# Selectable-Window Rounding Normalizer

This block narrows a wide two's-complement accumulator result to a short output word. A control word picks which contiguous run of bits becomes the output, so the caller trades headroom against resolution at run time. When rounding is enabled, half of the selected window's least significant weight is added to the wide value before the window is cut out. The rounding point therefore always follows the chosen window.

The block sits after a multiply-accumulate datapath. A result and its valid strobe arrive together with the control word, which is sampled in the same cycle. The narrowed word leaves one register stage later with a matching valid strobe. The output word holds its value between valid results.

Top module: `rnd_window_norm`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it rises, `vld_o` is 0 and `dout_o` is 0.
- R2: `vld_o` equals the value `vld_i` had at the previous rising clock edge.
- R3: If `vld_i` is 0 at an edge, `dout_o` keeps its value, whatever `data_i` and `ctrl_i` carry in that cycle.
- R4: The window code is `ctrl_i[3:0]`. A code k from 0 to 7 selects the output bits 39-3k down to 24-3k, so the tops are 39, 36, 33, 30, 27, 24, 21 and 18. Codes 8 to 15 select bits 39 down to 24.
- R5: With `ctrl_i[4]` = 1, rounding is off and `dout_o` is exactly the selected bits of `data_i`. For example, control 5'b11xxx gives bits 39..24.
- R6: With `ctrl_i[4]` = 0, the 40-bit input is sign-extended to 41 bits and 2^(top-16) is added before the window is taken. For example, control 5'b00010 rounds and gives bits 33..18. A remainder of exactly one half rounds up, and a remainder just below one half truncates.
- R7: The rounding carry ripples through the whole window. A window of 0x7FFF with the half bit set yields 0x8000, and an all-ones input yields 0.
- R8: `ctrl_i` is used in the same cycle as the `data_i` it accompanies. Changing it on every valid cycle gives each result its own window and rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Input result valid |
| data_i | input | 40 | Wide two's-complement result |
| ctrl_i | input | 5 | Bit 4: 1 disables rounding; bits 3:0: window code |
| vld_o | output | 1 | Output word valid, one cycle after `vld_i` |
| dout_o | output | 16 | Selected and optionally rounded window |

## Verification
Window selection and the rounding carry act in the same cycle. A half-LSB add can change every selected bit and can reach the window's top bit. Each window position is driven with inputs whose in-window bits are 0x7FFF, or all ones, with the half bit set. The output must show the carried value (0x8000 or 0) rather than the plain slice. A scoreboard model that knows only the requirement text judges each result. The bench also changes the control word on every valid cycle, which shows that selection and rounding are sampled with their own data.

// File: rtl/rwn_pkg.sv
package rwn_pkg;

   // Encoding of the rounding disable bit in the control word
   typedef enum logic {
      RND_ON  = 1'b0,
      RND_OFF = 1'b1
   } rnd_mode_e;

   // Bit index of the least significant bit of window position k
   function automatic int win_lsb(input int in_w, input int out_w,
                                  input int step, input int k);
      return in_w - out_w - step * k;
   endfunction

   // Bit index of the most significant bit of window position k
   function automatic int win_top(input int in_w, input int step,
                                  input int k);
      return in_w - 1 - step * k;
   endfunction

endpackage

// File: rtl/rwn_ctrl_decode.sv
module rwn_ctrl_decode
   import rwn_pkg::*;
#(
   parameter int unsigned SEL_W = 4,
   parameter int unsigned NPOS  = 8,
   localparam int unsigned POS_W = $clog2(NPOS)
) (
   input  logic [SEL_W:0]   ctrl_i,
   output logic [POS_W-1:0] pos_o,
   output logic             rnd_en_o
);

   logic [SEL_W-1:0] code;

   assign code = ctrl_i[SEL_W-1:0];

   // Codes beyond the last position fall back to the topmost window
   always_comb begin
      if (int'(code) < int'(NPOS)) pos_o = POS_W'(code);
      else                         pos_o = '0;
   end

   assign rnd_en_o = (rnd_mode_e'(ctrl_i[SEL_W]) == RND_ON);

endmodule

// File: rtl/rwn_round_add.sv
module rwn_round_add
   import rwn_pkg::*;
#(
   parameter int unsigned IN_W  = 40,
   parameter int unsigned OUT_W = 16,
   parameter int unsigned STEP  = 3,
   parameter int unsigned NPOS  = 8,
   parameter bit          ROUND_BY_SHIFT = 1'b1,
   localparam int unsigned POS_W = $clog2(NPOS),
   localparam int unsigned SUM_W = IN_W + 1
) (
   input  logic [IN_W-1:0]  data_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             rnd_en_i,
   output logic [SUM_W-1:0] sum_o
);

   logic [SUM_W-1:0] half;

   generate
      if (ROUND_BY_SHIFT) begin : g_shift
         // Barrel shift of a single one to the half-LSB place
         always_comb begin
            half = '0;
            if (rnd_en_i)
               half = SUM_W'(1) << (win_lsb(int'(IN_W), int'(OUT_W),
                                            int'(STEP), int'(pos_i)) - 1);
         end
      end else begin : g_table
         // One constant per window position, picked by a mux
         logic [SUM_W-1:0] tbl [NPOS];
         for (genvar k = 0; k < int'(NPOS); k++) begin : g_ent
            assign tbl[k] = SUM_W'(1) << (win_lsb(int'(IN_W), int'(OUT_W),
                                                  int'(STEP), k) - 1);
         end
         assign half = rnd_en_i ? tbl[pos_i] : '0;
      end
   endgenerate

   // Sign extension keeps the carry out of bit IN_W-1 in the sum
   assign sum_o = {data_i[IN_W-1], data_i} + half;

   always_comb begin
      AST_HALF_ONEHOT: assert ($onehot0(half)); // R6
   end

endmodule

// File: rtl/rwn_window_mux.sv
module rwn_window_mux
   import rwn_pkg::*;
#(
   parameter int unsigned IN_W  = 40,
   parameter int unsigned OUT_W = 16,
   parameter int unsigned STEP  = 3,
   parameter int unsigned NPOS  = 8,
   localparam int unsigned POS_W = $clog2(NPOS),
   localparam int unsigned SUM_W = IN_W + 1
) (
   input  logic [SUM_W-1:0] sum_i,
   input  logic [POS_W-1:0] pos_i,
   output logic [OUT_W-1:0] win_o
);

   logic [OUT_W-1:0] slc [NPOS];

   generate
      for (genvar k = 0; k < int'(NPOS); k++) begin : g_slice
         localparam int TOP_K = win_top(int'(IN_W), int'(STEP), k);
         assign slc[k] = sum_i[TOP_K -: OUT_W];
      end
   endgenerate

   assign win_o = slc[pos_i];

endmodule

// File: rtl/rnd_window_norm.sv
module rnd_window_norm
   import rwn_pkg::*;
#(
   parameter int unsigned IN_W  = 40,
   parameter int unsigned OUT_W = 16,
   parameter int unsigned SEL_W = 4,
   parameter int unsigned STEP  = 3,
   parameter int unsigned NPOS  = 8,
   parameter bit          ROUND_BY_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [39:0]      data_i,
   input  logic [4:0]       ctrl_i,
   output logic             vld_o,
   output logic [15:0]      dout_o
);

   localparam int unsigned POS_W = $clog2(NPOS);
   localparam int unsigned SUM_W = IN_W + 1;

   generate
      if (IN_W != 40 || OUT_W != 16 || SEL_W != 4) begin : g_bad_ports
         $error("port widths are fixed at 40 in, 16 out, 5 control bits");
      end
      if (NPOS < 2 || NPOS > (1 << SEL_W)) begin : g_bad_npos
         $error("NPOS must lie between 2 and 2**SEL_W");
      end
      if (int'(IN_W) - int'(OUT_W) < int'(STEP) * (int'(NPOS) - 1) + 1) begin : g_bad_span
         $error("lowest window leaves no bit for the half-LSB constant");
      end
   endgenerate

   logic [POS_W-1:0] pos;
   logic             rnd_en;
   logic [SUM_W-1:0] sum;
   logic [OUT_W-1:0] win;

   rwn_ctrl_decode #(
      .SEL_W (SEL_W),
      .NPOS  (NPOS)
   ) u_dec (
      .ctrl_i   (ctrl_i),
      .pos_o    (pos),
      .rnd_en_o (rnd_en)
   );

   rwn_round_add #(
      .IN_W           (IN_W),
      .OUT_W          (OUT_W),
      .STEP           (STEP),
      .NPOS           (NPOS),
      .ROUND_BY_SHIFT (ROUND_BY_SHIFT)
   ) u_add (
      .data_i   (data_i),
      .pos_i    (pos),
      .rnd_en_i (rnd_en),
      .sum_o    (sum)
   );

   rwn_window_mux #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W),
      .STEP  (STEP),
      .NPOS  (NPOS)
   ) u_mux (
      .sum_i (sum),
      .pos_i (pos),
      .win_o (win)
   );

   // Single output stage: valid always advances, data loads on valid
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         dout_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) dout_o <= win;
      end
   end

   // Reference slice of the raw input, taken without the adder or the mux
   logic [OUT_W-1:0] trunc_ref;
   always_comb begin
      trunc_ref = OUT_W'(data_i >> win_lsb(int'(IN_W), int'(OUT_W),
                                           int'(STEP), int'(pos)));
   end

   AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vld_o == $past(vld_i))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(vld_i)) |-> $stable(dout_o)); // R3

   AST_TRUNC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(vld_i) && $past(ctrl_i[SEL_W]))
      |-> (dout_o == $past(trunc_ref))); // R5

   AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(vld_i) && !$past(ctrl_i[SEL_W]))
      |-> (OUT_W'(dout_o - $past(trunc_ref)) <= OUT_W'(1))); // R6

endmodule

// File: tb/tb_rnd_window_norm.sv
module tb_rnd_window_norm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_i = 1'b0;
   logic [39:0] data_i = '0;
   logic [4:0]  ctrl_i = '0;
   logic        vld_o;
   logic [15:0] dout_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];
   logic [15:0] last_out = '0;
   logic        vld_seen = 1'b0;

   always #5 clk = ~clk;

   rnd_window_norm dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (vld_i),
      .data_i (data_i),
      .ctrl_i (ctrl_i),
      .vld_o  (vld_o),
      .dout_o (dout_o)
   );

   // Requirement model: window top and optional half-LSB rounding
   function automatic logic [15:0] model(input logic [39:0] d, input logic [4:0] c);
      int top;
      logic [40:0] s;
      top = (int'(c[3:0]) < 8) ? 39 - 3 * int'(c[3:0]) : 39;
      s = {d[39], d};
      if (!c[4]) s = s + (41'd1 << (top - 16));
      return s[top -: 16];
   endfunction

   function automatic int lsb_of(input logic [3:0] k);
      return (int'(k) < 8) ? 24 - 3 * int'(k) : 24;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [39:0] d, input logic [4:0] c,
                        input string tag);
      @(negedge clk);
      vld_i  = v;
      data_i = d;
      ctrl_i = c;
      if (v) begin
         exp_q.push_back(model(d, c));
         tag_q.push_back(tag);
      end
   endtask

   function automatic logic [39:0] rnd40();
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      return r[39:0];
   endfunction

   always @(posedge clk) vld_seen <= rst_n ? vld_i : 1'b0;

   // Monitor: pops expected words as valid results appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 vld_o", 32'(vld_o), 32'(vld_seen));
         if (vld_o) begin
            if (exp_q.size() == 0) begin
               check("R2 unexpected output", 32'(1), 32'(0));
            end else begin
               logic [15:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, 32'(dout_o), 32'(e));
               last_out = dout_o;
            end
         end else begin
            check("R3 hold", 32'(dout_o), 32'(last_out));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, checked during reset
      repeat (3) @(negedge clk);
      check("R1 vld_o", 32'(vld_o), 32'(0));
      check("R1 dout_o", 32'(dout_o), 32'(0));
      rst_n = 1'b1;

      // R4 / R6: every control value with random data, idle gaps for R3
      for (int c = 0; c < 32; c++) begin
         for (int i = 0; i < 6; i++) begin
            drive(1'b1, rnd40(), 5'(c), c[4] ? "R4 window" : "R6 rounding");
            if (i == 2) drive(1'b0, rnd40(), 5'($urandom()), "R3 idle");
         end
      end

      // R5: exact slices with rounding off, corner data
      for (int k = 0; k < 16; k++) begin
         drive(1'b1, 40'hFF_FFFF_FFFF, {1'b1, 4'(k)}, "R5 ones");
         drive(1'b1, 40'h80_0000_0000, {1'b1, 4'(k)}, "R5 min");
         drive(1'b1, 40'h7F_FFFF_FFFF, {1'b1, 4'(k)}, "R5 max");
         drive(1'b1, 40'h00_0000_0000, {1'b1, 4'(k)}, "R5 zero");
      end

      // R6: exact half rounds up, just below half truncates
      for (int k = 0; k < 16; k++) begin
         int lb;
         lb = lsb_of(4'(k));
         drive(1'b1, 40'd1 << (lb - 1), {1'b0, 4'(k)}, "R6 half");
         drive(1'b1, (40'd1 << (lb - 1)) - 40'd1, {1'b0, 4'(k)}, "R6 below");
         drive(1'b1, (40'd3 << lb) | (40'd1 << (lb - 1)), {1'b0, 4'(k)}, "R6 odd");
      end

      // R7: carry through the full window
      for (int k = 0; k < 16; k++) begin
         int lb;
         lb = lsb_of(4'(k));
         drive(1'b1, (40'h7FFF << lb) | (40'd1 << (lb - 1)), {1'b0, 4'(k)}, "R7 ripple");
         drive(1'b1, 40'hFF_FFFF_FFFF, {1'b0, 4'(k)}, "R7 ones");
         drive(1'b1, 40'h7F_FFFF_FFFF, {1'b0, 4'(k)}, "R7 top");
      end

      // R8: control changes on every valid cycle
      for (int i = 0; i < 64; i++) begin
         drive(1'b1, rnd40(), 5'($urandom()), "R8 switch");
      end

      drive(1'b0, rnd40(), 5'd0, "R3 idle");
      drive(1'b0, 40'hFF_FFFF_FFFF, 5'd5, "R3 idle");
      repeat (3) @(negedge clk);
      check("R2 queue drained", 32'(exp_q.size()), 32'(0));

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule